// File: doc/BRIEF.md
# Query Report Write Engine

This block turns a write to a query-control register into one or two memory-write requests. The requests place a query result at an address that software programmed beforehand. Software first loads a target address and a 32-bit sequence value through a small register-write port. It then writes the control word, which starts the report.

The operation field of the control word picks what happens:

- **Release** reports the sequence value.
- **Counter** reports a value taken from a selectable source: constant zero, a samples-passed counter, or the constant one for any source code the block does not know.
- **Acquire** and **Trap** write nothing. They only raise a one-cycle unsupported pulse.

A report is either short or long:

- A **short** report is a single 4-byte write of the low 32 bits of the result.
- A **long** report is two 8-byte beats. The first beat carries the 64-bit result. The second beat carries the timestamp captured when the control word was accepted.

The samples-passed counter counts pulses on a sample input while its enable register is nonzero. A dedicated command register clears it when code 0x01 is written. Any other code written there is accepted and has no effect.

Top module: `qrep_engine`

## Requirements
- R1: Register select codes are 0 = address low 32 bits, 1 = address upper bits, 2 = sequence, 3 = control (a write here starts an operation), 4 = sample-count enable, 5 = counter command. A write is taken only in a cycle where `cfg_we` and `cfg_ready` are both high.
- R2: Control bits [1:0] hold the operation (0 Release, 1 Acquire, 2 Counter, 3 Trap). A Release reports the programmed sequence value, zero-extended to 64 bits.
- R3: When control bit 28 (short flag) is 1, a Release or Counter produces exactly one beat. That beat has `wr_addr` = programmed address, `wr_bytes` = 4, `wr_last` = 1, and `wr_data` = the low 32 bits of the result with bits [63:32] zero.
- R4: When bit 28 is 0, the report is two beats, each with `wr_bytes` = 8. Beat 1 carries the 64-bit result at the programmed address with `wr_last` = 0. Beat 2 carries `stamp_time` as sampled in the cycle the control write was taken, at address + 8, with `wr_last` = 1.
- R5: For a Counter operation, control bits [27:24] select the source: 0 reports 0, 2 reports the samples-passed count, and every other code reports 1.
- R6: The samples-passed count increments by one on each clock with `sample_tick` high while the enable register (select 4) is nonzero. It holds while the enable register is zero.
- R7: Writing 0x00000001 to the counter command register (select 5) clears the count to zero. Any other value, for example 0x10 or 0x1F, leaves the count unchanged.
- R8: Acquire and Trap produce no write beat. They raise `unsup_pulse` for exactly one cycle, the cycle after the control write.
- R9: `cfg_ready` is low from the cycle after a reporting control write until the final beat has been accepted. While `wr_valid` is high and `wr_ready` is low, the address, data, byte count and last flag hold steady.
- R10: After reset, `wr_valid` and `unsup_pulse` are low, `cfg_ready` is high, and the samples-passed count is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 32 | Register write data |
| cfg_ready | output | 1 | High when a register write can be taken |
| stamp_time | input | 64 | Free-running timestamp |
| sample_tick | input | 1 | One sample passed this cycle |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write beat accepted |
| wr_addr | output | ADDR_W (40) | Byte address of the beat |
| wr_data | output | 64 | Beat data, little-endian |
| wr_bytes | output | 4 | Number of valid bytes in the beat (4 or 8) |
| wr_last | output | 1 | Final beat of the report |
| unsup_pulse | output | 1 | One-cycle flag for Acquire or Trap |

## Verification
The bench aims at the points where a report is easy to get subtly wrong.

- **Short versus long.** A design that ignored the short flag would send 8 bytes where 4 are expected, or a single beat where two are expected.
- **Timestamp.** If the timestamp were taken at the beat instead of at the control write, the second beat would carry a later count.
- **Address of the second beat.** A wrong offset on the second beat would land the timestamp over the value.
- **Counter sources.** Unknown source codes must report 1, not 0.
- **Counter gating.** A disabled counter must not move, and the 0x10 and 0x1F commands must leave the count alone.
- **Unsupported operations.** Acquire and Trap must write nothing. A design that treated them as Release would issue a beat.
- **Backpressure.** With `wr_ready` held low, the bench checks that the first beat stays put and that `cfg_ready` stays low until the second beat is accepted.

// File: rtl/qrep_pkg.sv
// Shared types for the query report write engine.
// Holds the register select codes, the operation encoding, the decoded
// control fields and the emitter state. Assumes a 32-bit register port.
package qrep_pkg;

    localparam int CFG_W  = 32;
    localparam int BEAT_W = 64;
    localparam int BYTES_W = 4;

    localparam logic [2:0] SEL_ADDR_LO = 3'd0;
    localparam logic [2:0] SEL_ADDR_HI = 3'd1;
    localparam logic [2:0] SEL_SEQ     = 3'd2;
    localparam logic [2:0] SEL_CTRL    = 3'd3;
    localparam logic [2:0] SEL_CNT_EN  = 3'd4;
    localparam logic [2:0] SEL_CNT_CMD = 3'd5;

    localparam logic [3:0] SRC_ZERO    = 4'd0;
    localparam logic [3:0] SRC_SAMPLES = 4'd2;

    localparam logic [CFG_W-1:0] CMD_CLEAR_SAMPLES = 32'h0000_0001;

    typedef enum logic [1:0] {
        OP_RELEASE = 2'd0,
        OP_ACQUIRE = 2'd1,
        OP_COUNTER = 2'd2,
        OP_TRAP    = 2'd3
    } qop_e;

    typedef struct packed {
        qop_e       op;
        logic [3:0] src;
        logic       short_rpt;
    } qctl_t;

    typedef enum logic [1:0] {
        EM_IDLE  = 2'd0,
        EM_BEAT0 = 2'd1,
        EM_BEAT1 = 2'd2
    } em_state_e;

    // Pull the fields the engine acts on out of a control word.
    function automatic qctl_t decode_ctl(input logic [CFG_W-1:0] w);
        qctl_t c;
        c.op        = qop_e'(w[1:0]);
        c.src       = w[27:24];
        c.short_rpt = w[28];
        return c;
    endfunction

endpackage

// File: rtl/qrep_regs.sv
// Register file of the query report engine.
// Holds the target address, the sequence value and the counter enable.
// Turns writes to the control and counter-command registers into one-cycle
// strobes. Assumes the caller gates writes with its own ready signal.
module qrep_regs
    import qrep_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_take,
    input  logic [2:0]           sel,
    input  logic [CFG_W-1:0]     wdata,
    output logic [ADDR_W-1:0]    query_addr,
    output logic [CFG_W-1:0]     seq_val,
    output logic                 count_en,
    output logic                 trig,
    output qctl_t                trig_ctl,
    output logic                 count_clr
);
    localparam int HI_W = ADDR_W - CFG_W;

    logic [CFG_W-1:0] addr_lo_q;
    logic [HI_W-1:0]  addr_hi_q;
    logic [CFG_W-1:0] seq_q;
    logic [CFG_W-1:0] en_q;

    // Store the address, sequence and enable registers on accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo_q <= '0;
            addr_hi_q <= '0;
            seq_q     <= '0;
            en_q      <= '0;
        end else if (wr_take) begin
            case (sel)
                SEL_ADDR_LO: addr_lo_q <= wdata;
                SEL_ADDR_HI: addr_hi_q <= wdata[HI_W-1:0];
                SEL_SEQ:     seq_q     <= wdata;
                SEL_CNT_EN:  en_q      <= wdata;
                default:     ;
            endcase
        end
    end

    // Produce the start strobe, the decoded control and the clear strobe.
    always_comb begin
        trig      = wr_take && (sel == SEL_CTRL);
        trig_ctl  = decode_ctl(wdata);
        count_clr = wr_take && (sel == SEL_CNT_CMD) && (wdata == CMD_CLEAR_SAMPLES);
    end

    assign query_addr = {addr_hi_q, addr_lo_q};
    assign seq_val    = seq_q;
    assign count_en   = |en_q;

endmodule

// File: rtl/qrep_sample_ctr.sv
// Samples-passed counter.
// Counts tick pulses while enabled. A clear strobe wins over a tick that
// arrives in the same cycle. Wraps silently at its width.
module qrep_sample_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    // Clear on command, otherwise count enabled ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (en && tick) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/qrep_source.sv
// Result source selection.
// Maps the operation and source code of a control word to a 64-bit payload.
// Also says whether a report is written at all. Pure combinational logic.
module qrep_source
    import qrep_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  qctl_t              ctl,
    input  logic [CFG_W-1:0]   seq_val,
    input  logic [CNT_W-1:0]   count,
    output logic [BEAT_W-1:0]  payload,
    output logic               writes
);
    localparam int CPAD = BEAT_W - CNT_W;
    localparam int SPAD = BEAT_W - CFG_W;

    // Choose the payload and whether memory is written.
    always_comb begin
        payload = '0;
        writes  = 1'b0;
        case (ctl.op)
            OP_RELEASE: begin
                payload = {{SPAD{1'b0}}, seq_val};
                writes  = 1'b1;
            end
            OP_COUNTER: begin
                writes = 1'b1;
                if (ctl.src == SRC_ZERO)
                    payload = '0;
                else if (ctl.src == SRC_SAMPLES)
                    payload = {{CPAD{1'b0}}, count};
                else
                    payload = {{(BEAT_W-1){1'b0}}, 1'b1};
            end
            default: begin
                payload = '0;
                writes  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/qrep_emit.sv
// Beat emitter.
// Captures the payload, address, timestamp and format when a report starts.
// Then presents one short beat, or two long beats (value, then timestamp at
// +8). Busy until the last beat is accepted. Pulses the unsupported flag for
// operations that write nothing.
module qrep_emit
    import qrep_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int TS_W   = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trig,
    input  logic                writes,
    input  logic                short_rpt,
    input  logic [ADDR_W-1:0]   addr_in,
    input  logic [BEAT_W-1:0]   payload,
    input  logic [TS_W-1:0]     stamp,
    output logic                busy,
    output logic                unsup,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [BEAT_W-1:0]   wr_data,
    output logic [BYTES_W-1:0]  wr_bytes,
    output logic                wr_last
);
    localparam int TPAD = BEAT_W - TS_W;
    localparam int HALF = BEAT_W / 2;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BEAT_W / 8);

    em_state_e            state_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [BEAT_W-1:0]    val_q;
    logic [TS_W-1:0]      ts_q;
    logic                 long_q;
    logic                 unsup_q;

    // Sequence the beats of a report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EM_IDLE;
        end else begin
            case (state_q)
                EM_IDLE:  if (trig && writes) state_q <= EM_BEAT0;
                EM_BEAT0: if (wr_ready) state_q <= long_q ? EM_BEAT1 : EM_IDLE;
                EM_BEAT1: if (wr_ready) state_q <= EM_IDLE;
                default:  state_q <= EM_IDLE;
            endcase
        end
    end

    // Capture the report contents at the start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            val_q  <= '0;
            ts_q   <= '0;
            long_q <= 1'b0;
        end else if (state_q == EM_IDLE && trig && writes) begin
            addr_q <= addr_in;
            val_q  <= payload;
            ts_q   <= stamp;
            long_q <= !short_rpt;
        end
    end

    // Flag operations that start but write nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) unsup_q <= 1'b0;
        else        unsup_q <= (state_q == EM_IDLE) && trig && !writes;
    end

    // Form the outgoing beat from state and captured contents.
    always_comb begin
        wr_valid = (state_q != EM_IDLE);
        wr_addr  = (state_q == EM_BEAT1) ? addr_q + STEP : addr_q;
        if (state_q == EM_BEAT1)
            wr_data = {{TPAD{1'b0}}, ts_q};
        else if (long_q)
            wr_data = val_q;
        else
            wr_data = {{HALF{1'b0}}, val_q[HALF-1:0]};
        wr_bytes = long_q ? BYTES_W'(BEAT_W / 8) : BYTES_W'(HALF / 8);
        wr_last  = (state_q == EM_BEAT1) || (state_q == EM_BEAT0 && !long_q);
    end

    assign busy  = (state_q != EM_IDLE);
    assign unsup = unsup_q;

endmodule

// File: rtl/qrep_engine.sv
// Query report write engine, top level.
// Register writes program a target and start reports. The reports leave
// through a valid/ready write-request port. The register port is held off
// while a report is in flight. Assumes ADDR_W > 32 and counters of at most
// 64 bits.
module qrep_engine
    import qrep_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int CNT_W  = 32,
    parameter int TS_W   = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_sel,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output logic                cfg_ready,
    input  logic [TS_W-1:0]     stamp_time,
    input  logic                sample_tick,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [BEAT_W-1:0]   wr_data,
    output logic [BYTES_W-1:0]  wr_bytes,
    output logic                wr_last,
    output logic                unsup_pulse
);
    logic               busy;
    logic               wr_take;
    logic [ADDR_W-1:0]  query_addr;
    logic [CFG_W-1:0]   seq_val;
    logic               count_en;
    logic               trig;
    qctl_t              trig_ctl;
    logic               count_clr;
    logic [CNT_W-1:0]   count;
    logic [BEAT_W-1:0]  payload;
    logic               writes;

    assign cfg_ready = !busy;
    assign wr_take   = cfg_we && !busy;

    qrep_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_take    (wr_take),
        .sel        (cfg_sel),
        .wdata      (cfg_wdata),
        .query_addr (query_addr),
        .seq_val    (seq_val),
        .count_en   (count_en),
        .trig       (trig),
        .trig_ctl   (trig_ctl),
        .count_clr  (count_clr)
    );

    qrep_sample_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (count_en),
        .tick  (sample_tick),
        .clr   (count_clr),
        .count (count)
    );

    qrep_source #(.CNT_W(CNT_W)) u_src (
        .ctl     (trig_ctl),
        .seq_val (seq_val),
        .count   (count),
        .payload (payload),
        .writes  (writes)
    );

    qrep_emit #(.ADDR_W(ADDR_W), .TS_W(TS_W)) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .writes    (writes),
        .short_rpt (trig_ctl.short_rpt),
        .addr_in   (query_addr),
        .payload   (payload),
        .stamp     (stamp_time),
        .busy      (busy),
        .unsup     (unsup_pulse),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_bytes  (wr_bytes),
        .wr_last   (wr_last)
    );

endmodule

// File: rtl/qrep_engine_checker.sv
// Protocol checker for the query report write engine, attached by bind.
// Watches only the top-level ports.
module qrep_engine_checker #(
    parameter int ADDR_W = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_ready,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [63:0]       wr_data,
    input logic [3:0]        wr_bytes,
    input logic              wr_last,
    input logic              unsup_pulse
);
    assert_hold_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)
                                     && $stable(wr_bytes) && $stable(wr_last)));

    assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !cfg_ready);

    assert_beat_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ((wr_bytes == 4'd4 && wr_last) || wr_bytes == 4'd8));

    assert_second_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && !wr_last) |=>
            (wr_valid && wr_last && wr_bytes == 4'd8 && wr_addr == $past(wr_addr) + ADDR_W'(8)));

    assert_pulse_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        unsup_pulse |=> !unsup_pulse);

    assert_pulse_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        unsup_pulse |-> !wr_valid);

    assert_reset_idle_R10: assert property (@(posedge clk)
        !rst_n |=> (!wr_valid && !unsup_pulse && cfg_ready));

endmodule

bind qrep_engine qrep_engine_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_ready   (cfg_ready),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_bytes    (wr_bytes),
    .wr_last     (wr_last),
    .unsup_pulse (unsup_pulse)
);

// File: tb/qrep_engine_bench.sv
`timescale 1ns/1ps
// Directed bench for the query report write engine, one task per scenario.
module qrep_engine_bench;
    localparam int ADDR_W = 40;
    localparam logic [ADDR_W-1:0] BASE = 40'h12_3456_7800;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_sel = '0;
    logic [31:0]       cfg_wdata = '0;
    logic              cfg_ready;
    logic [63:0]       stamp_time = 64'h100;
    logic              sample_tick = 1'b0;
    logic              wr_valid;
    logic              wr_ready = 1'b1;
    logic [ADDR_W-1:0] wr_addr;
    logic [63:0]       wr_data;
    logic [3:0]        wr_bytes;
    logic              wr_last;
    logic              unsup_pulse;

    int total = 0;
    int bad = 0;
    int nb = 0;
    int n_unsup = 0;
    logic [63:0]       b_data [8];
    logic [ADDR_W-1:0] b_addr [8];
    logic [3:0]        b_bytes [8];
    logic              b_last [8];
    logic [63:0]       ts_at_trig;

    always #2.5 clk = ~clk;

    qrep_engine u_qrep_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_ready(cfg_ready), .stamp_time(stamp_time),
        .sample_tick(sample_tick), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_bytes(wr_bytes),
        .wr_last(wr_last), .unsup_pulse(unsup_pulse)
    );

    // Free-running timestamp, advanced away from the active edge.
    always @(negedge clk) stamp_time <= stamp_time + 64'd1;

    // Record accepted beats and unsupported pulses.
    always @(negedge clk) begin
        if (rst_n && wr_valid && wr_ready && nb < 8) begin
            b_data[nb]  = wr_data;
            b_addr[nb]  = wr_addr;
            b_bytes[nb] = wr_bytes;
            b_last[nb]  = wr_last;
            nb = nb + 1;
        end
        if (rst_n && unsup_pulse) n_unsup = n_unsup + 1;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        #1 ts_at_trig = stamp_time;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] ctl(input logic [1:0] op, input logic [3:0] src, input bit shrt);
        return {3'b0, shrt, src, 22'b0, op};
    endfunction

    task automatic run_query(input logic [31:0] c);
        nb = 0; n_unsup = 0;
        cfg_write(3'd3, c);
        repeat (6) @(negedge clk);
    endtask

    task automatic check_short(input string tag, input logic [63:0] exp);
        check(nb == 1, {tag, " beat count"}, 64'(nb), 64'd1);
        check(b_data[0] == exp && b_bytes[0] == 4'd4 && b_last[0] && b_addr[0] == BASE,
              {tag, " short beat"}, b_data[0], exp);
    endtask

    task automatic check_long(input string tag, input logic [63:0] exp, input logic [63:0] ts);
        check(nb == 2, {tag, " beat count"}, 64'(nb), 64'd2);
        check(b_data[0] == exp && b_bytes[0] == 4'd8 && !b_last[0] && b_addr[0] == BASE,
              {tag, " long value beat"}, b_data[0], exp);
        check(b_data[1] == ts && b_bytes[1] == 4'd8 && b_last[1] && b_addr[1] == BASE + 40'd8,
              {tag, " long stamp beat"}, b_data[1], ts);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(!wr_valid && !unsup_pulse && cfg_ready, "R10 reset outputs", 64'(wr_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg_ready && !wr_valid, "R10 idle after reset", 64'(cfg_ready), 64'd1);
    endtask

    task automatic t_program();
        cfg_write(3'd0, BASE[31:0]);
        cfg_write(3'd1, {24'b0, BASE[39:32]});
        cfg_write(3'd2, 32'hCAFE_0001);
    endtask

    task automatic t_release_short();
        run_query(ctl(2'd0, 4'd0, 1'b1));
        check_short("R2 R3 R1 release short", 64'h0000_0000_CAFE_0001);
    endtask

    task automatic t_release_long();
        run_query(ctl(2'd0, 4'd0, 1'b0));
        check_long("R2 R4 release long", 64'h0000_0000_CAFE_0001, ts_at_trig);
    endtask

    task automatic t_counter_zero();
        run_query(ctl(2'd2, 4'd0, 1'b0));
        check_long("R5 counter zero", 64'd0, ts_at_trig);
    endtask

    task automatic t_samples();
        run_query(ctl(2'd2, 4'd2, 1'b1));
        check_short("R10 count zero after reset", 64'd0);
        cfg_write(3'd4, 32'd1);
        @(negedge clk); sample_tick = 1'b1;
        repeat (5) @(negedge clk);
        sample_tick = 1'b0;
        run_query(ctl(2'd2, 4'd2, 1'b1));
        check_short("R6 R5 samples counted", 64'd5);
        cfg_write(3'd4, 32'd0);
        @(negedge clk); sample_tick = 1'b1;
        repeat (3) @(negedge clk);
        sample_tick = 1'b0;
        run_query(ctl(2'd2, 4'd2, 1'b0));
        check_long("R6 disabled count holds", 64'd5, ts_at_trig);
    endtask

    task automatic t_counter_cmd();
        cfg_write(3'd5, 32'h10);
        cfg_write(3'd5, 32'h1F);
        run_query(ctl(2'd2, 4'd2, 1'b1));
        check_short("R7 other codes ignored", 64'd5);
        cfg_write(3'd5, 32'h01);
        run_query(ctl(2'd2, 4'd2, 1'b1));
        check_short("R7 clear code", 64'd0);
    endtask

    task automatic t_unknown_src();
        run_query(ctl(2'd2, 4'd7, 1'b1));
        check_short("R5 unknown source", 64'd1);
        run_query(ctl(2'd2, 4'd15, 1'b0));
        check_long("R5 unknown source long", 64'd1, ts_at_trig);
    endtask

    task automatic t_unsupported();
        run_query(ctl(2'd1, 4'd0, 1'b0));
        check(nb == 0, "R8 acquire no write", 64'(nb), 64'd0);
        check(n_unsup == 1, "R8 acquire pulse", 64'(n_unsup), 64'd1);
        run_query(ctl(2'd3, 4'd0, 1'b1));
        check(nb == 0, "R8 trap no write", 64'(nb), 64'd0);
        check(n_unsup == 1, "R8 trap pulse", 64'(n_unsup), 64'd1);
        check(cfg_ready, "R8 ready after trap", 64'(cfg_ready), 64'd1);
    endtask

    task automatic t_backpressure();
        logic [63:0] ts;
        @(posedge clk); #1 wr_ready = 1'b0;
        nb = 0;
        cfg_write(3'd3, ctl(2'd0, 4'd0, 1'b0));
        ts = ts_at_trig;
        repeat (4) @(negedge clk);
        check(wr_valid && wr_data == 64'hCAFE_0001 && wr_addr == BASE, "R9 beat held",
              wr_data, 64'hCAFE_0001);
        check(!cfg_ready, "R9 port busy", 64'(cfg_ready), 64'd0);
        @(posedge clk); #1 wr_ready = 1'b1;
        repeat (4) @(negedge clk);
        check_long("R9 after stall", 64'hCAFE_0001, ts);
        check(cfg_ready, "R9 ready again", 64'(cfg_ready), 64'd1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_program();
                t_release_short();
                t_release_long();
                t_counter_zero();
                t_samples();
                t_counter_cmd();
                t_unknown_src();
                t_unsupported();
                t_backpressure();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule